// File: doc/BRIEF.md
# Performance-Monitor Register Access Gate

This block sits between the move-to/move-from special-register port of an execution pipeline and a small performance-monitor register file. The file holds two monitor control words (control word 0 and control word 2) and six event counters. Each request carries a register number, a read/write flag, a privilege flag and 64 bits of write data. The block answers one clock later with read data, a grant flag and a fault code.

Privileged requests always go through, with all 64 bits visible. User-mode requests are judged against a two-bit counter-access field held in control word 0. Depending on that field, the register addressed and the direction of the access, a user-mode request is granted, refused with a facility-unavailable fault or refused with a hypervisor-emulation fault. Granted user-mode accesses to the control words see only a narrow set of bits. Reads return only those bits. Writes merge the data into those bits and leave every other bit as it was. Counting events and raising interrupts are handled elsewhere.

Top module: `pmu_access_gate`

## Requirements
- R1: A request sampled on a rising edge while `req_valid` is high produces `rsp_valid` high for exactly the following cycle. With no request, `rsp_valid`, `rsp_grant`, `rsp_fault` and `rsp_rdata` are all zero.
- R2: A privileged request to any mapped number, through either alias, is granted. It reads and writes all 64 bits unmasked.
- R3: A user-mode read of a counter 1 to 4 or of either control word faults with code 2'b01 when the access field is 2'b01. For any other field value it is granted.
- R4: A user-mode write to those same registers is granted when the access field is 2'b10 or 2'b11. It faults with code 2'b10 when the field is 2'b00 and with code 2'b01 when the field is 2'b01.
- R5: When the access field is 2'b11, any user-mode read or write of counters 5 or 6 faults with code 2'b01. This check takes precedence over the R3 and R4 rules.
- R6: A granted user-mode read of control word 0 returns only bits 31 (freeze-all), 26 (alert enable) and 7 (alert occurred). All other bits read zero.
- R7: A granted user-mode read of control word 2 returns only the per-counter user freeze bits at positions 0, 9, 18, 27, 36 and 45. All other bits read zero.
- R8: A granted user-mode write to a control word replaces only the bits of its R6/R7 mask and keeps the rest, including the access field at bits 19:18. A granted user-mode write to a counter replaces the whole word.
- R9: User-mode numbers are 0x040+k and privileged numbers are 0x050+k (the user number plus 0x10). Both address the same storage. Here k = 0..5 selects counters 1..6, k = 6 selects control word 0 and k = 7 selects control word 2.
- R10: A faulted access changes no register, returns zero read data and deasserts grant. Fault codes are 2'b00 none, 2'b01 facility-unavailable and 2'b10 hypervisor-emulation. The code 2'b11 is never produced.
- R11: A number outside the map responds with zero data, no grant and no fault, and writes nothing. A user-mode request to a privileged number counts as outside the map.
- R12: After reset every register reads zero and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_regnum | input | 10 | Register number |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| req_priv | input | 1 | 1 = privileged, 0 = user mode |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Read data, zero unless a read was granted |
| rsp_grant | output | 1 | Access performed |
| rsp_fault | output | 2 | Fault code |

## Verification
Every response field and every register update caused by a request sampled on one rising edge becomes visible after that same edge. The response therefore belongs to the cycle that follows the request. The bench drives each request on a falling edge and pushes its predicted response into a queue. A monitor then compares the outputs on the next falling edge, which is half a period after the registering edge. Register contents are observed only through later privileged reads, so each write is judged one request later, again with a one-cycle response.

// File: rtl/pmu_gate_pkg.sv
package pmu_gate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'b00,
    FLT_FACILITY = 2'b01,
    FLT_HYPERV   = 2'b10
  } fault_e;

  localparam int unsigned FRZ_ALL_BIT   = 31;
  localparam int unsigned ALERT_EN_BIT  = 26;
  localparam int unsigned ALERT_OCC_BIT = 7;
  localparam int unsigned ACC_LO_BIT    = 18;
  localparam int unsigned FRZ_STRIDE    = 9;

endpackage

// File: rtl/pmu_gate_decode.sv
module pmu_gate_decode
  import pmu_gate_pkg::*;
#(
  parameter int REG_W      = 10,
  parameter int NUM_CNT    = 6,
  parameter int EXCL_FIRST = 4,
  parameter int USER_BASE  = 'h040,
  parameter int PRIV_SHIFT = 'h010,
  localparam int NSLOT     = NUM_CNT + 2,
  localparam int SLOT_W    = $clog2(NSLOT)
) (
  input  logic [REG_W-1:0]  req_regnum,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [1:0]        acc,
  output logic              hit,
  output logic              user_path,
  output logic [SLOT_W-1:0] slot,
  output fault_e            fault
);

  localparam int PRIV_BASE = USER_BASE + PRIV_SHIFT;

  int   rn;
  logic in_user;
  logic in_priv;
  logic excluded;

  always_comb begin
    rn        = int'(req_regnum);
    in_user   = (rn >= USER_BASE) && (rn < USER_BASE + NSLOT);
    in_priv   = (rn >= PRIV_BASE) && (rn < PRIV_BASE + NSLOT);
    slot      = in_priv ? SLOT_W'(rn - PRIV_BASE) : SLOT_W'(rn - USER_BASE);
    hit       = in_user || (in_priv && req_priv);
    user_path = in_user && !req_priv;
    excluded  = (int'(slot) >= EXCL_FIRST) && (int'(slot) < NUM_CNT);
    fault     = FLT_NONE;
    if (user_path) begin
      if (excluded && (acc == 2'b11)) begin
        fault = FLT_FACILITY;
      end else if (req_write) begin
        if (!acc[1]) fault = acc[0] ? FLT_FACILITY : FLT_HYPERV;
      end else if (acc == 2'b01) begin
        fault = FLT_FACILITY;
      end
    end
  end

endmodule

// File: rtl/pmu_gate_mask.sv
module pmu_gate_mask
  import pmu_gate_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_CNT  = 6,
  localparam int NSLOT   = NUM_CNT + 2,
  localparam int SLOT_W  = $clog2(NSLOT)
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic              user_path,
  output logic [DATA_W-1:0] mask
);

  function automatic logic [DATA_W-1:0] ctl0_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    m[FRZ_ALL_BIT]   = 1'b1;
    m[ALERT_EN_BIT]  = 1'b1;
    m[ALERT_OCC_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] ctl2_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CNT; i++) m[FRZ_STRIDE*i] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] MASK_CTL0 = ctl0_mask_f();
  localparam logic [DATA_W-1:0] MASK_CTL2 = ctl2_mask_f();

  always_comb begin
    if (!user_path)                        mask = '1;
    else if (slot == SLOT_W'(NUM_CNT))     mask = MASK_CTL0;
    else if (slot == SLOT_W'(NUM_CNT + 1)) mask = MASK_CTL2;
    else                                   mask = '1;
  end

endmodule

// File: rtl/pmu_gate_regs.sv
module pmu_gate_regs
  import pmu_gate_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int NUM_CNT = 6,
  localparam int NSLOT  = NUM_CNT + 2,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_raw,
  output logic [1:0]        acc
);

  logic [DATA_W-1:0] regs_q [NSLOT];
  logic [DATA_W-1:0] regs_d [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic sel;
    always_comb begin
      sel       = wr_en && (slot == SLOT_W'(g));
      regs_d[g] = sel ? ((regs_q[g] & ~wr_mask) | (wr_data & wr_mask)) : regs_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (sel) regs_q[g] <= regs_d[g];
    end
  end

  always_comb begin
    rd_raw = (int'(slot) < NSLOT) ? regs_q[slot] : '0;
    acc    = regs_q[NUM_CNT][ACC_LO_BIT+1:ACC_LO_BIT];
  end

endmodule

// File: rtl/pmu_access_gate.sv
module pmu_access_gate
  import pmu_gate_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int REG_W      = 10,
  parameter int NUM_CNT    = 6,
  parameter int EXCL_FIRST = 4,
  parameter int USER_BASE  = 'h040,
  parameter int PRIV_SHIFT = 'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [REG_W-1:0]  req_regnum,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_grant,
  output logic [1:0]        rsp_fault
);

  localparam int NSLOT  = NUM_CNT + 2;
  localparam int SLOT_W = $clog2(NSLOT);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              hit;
  logic              user_path;
  logic [SLOT_W-1:0] slot;
  fault_e            fault;
  logic [1:0]        ctl_acc;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] rd_raw;
  logic              wr_en;

  logic              valid_d, grant_d;
  logic [1:0]        fault_d;
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pmu_gate_decode #(
    .REG_W(REG_W), .NUM_CNT(NUM_CNT), .EXCL_FIRST(EXCL_FIRST),
    .USER_BASE(USER_BASE), .PRIV_SHIFT(PRIV_SHIFT)
  ) u_decode (
    .req_regnum(req_regnum), .req_write(req_write), .req_priv(req_priv),
    .acc(ctl_acc), .hit(hit), .user_path(user_path), .slot(slot), .fault(fault)
  );

  pmu_gate_mask #(.DATA_W(DATA_W), .NUM_CNT(NUM_CNT)) u_mask (
    .slot(slot), .user_path(user_path), .mask(mask)
  );

  pmu_gate_regs #(.DATA_W(DATA_W), .NUM_CNT(NUM_CNT)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .slot(slot),
    .wr_mask(mask), .wr_data(req_wdata), .rd_raw(rd_raw), .acc(ctl_acc)
  );

  always_comb begin
    valid_d = req_valid;
    grant_d = req_valid && hit && (fault == FLT_NONE);
    fault_d = (req_valid && hit) ? fault : FLT_NONE;
    wr_en   = grant_d && req_write;
    rdata_d = (grant_d && !req_write) ? (rd_raw & mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_fault <= FLT_NONE;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= valid_d;
      rsp_grant <= grant_d;
      rsp_fault <= fault_d;
      rsp_rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/pmu_access_gate_chk.sv
module pmu_access_gate_chk #(
  parameter int DATA_W     = 64,
  parameter int REG_W      = 10,
  parameter int NUM_CNT    = 6,
  parameter int USER_BASE  = 'h040,
  parameter int PRIV_SHIFT = 'h010
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [REG_W-1:0]  req_regnum,
  input logic              req_write,
  input logic              req_priv,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_grant,
  input logic [1:0]        rsp_fault,
  input logic [1:0]        acc
);

  localparam int NSLOT     = NUM_CNT + 2;
  localparam int PRIV_BASE = USER_BASE + PRIV_SHIFT;

  function automatic logic [DATA_W-1:0] ctl0_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    m[31] = 1'b1;
    m[26] = 1'b1;
    m[7]  = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] CTL0_VIS = ctl0_mask_f();

  logic in_user, in_any, ctl0_user_rd;
  always_comb begin
    in_user = (int'(req_regnum) >= USER_BASE) && (int'(req_regnum) < USER_BASE + NSLOT);
    in_any  = in_user ||
              ((int'(req_regnum) >= PRIV_BASE) && (int'(req_regnum) < PRIV_BASE + NSLOT));
    ctl0_user_rd = req_valid && !req_priv && !req_write &&
                   (int'(req_regnum) == USER_BASE + NUM_CNT);
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_grant && rsp_fault == 2'b00));
  assert_priv_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv && in_any) |=> (rsp_grant && rsp_fault == 2'b00));
  assert_read_fac_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && !req_write && in_user && acc == 2'b01) |=> rsp_fault == 2'b01);
  assert_hv_only_user_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault == 2'b10) |-> $past(req_valid && req_write && !req_priv));
  assert_ctl0_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl0_user_rd |=> ((rsp_rdata & ~CTL0_VIS) == '0));
  assert_fault_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'b00) |-> (!rsp_grant && rsp_rdata == '0));
  assert_fault_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault != 2'b11);

endmodule

bind pmu_access_gate pmu_access_gate_chk #(
  .DATA_W(DATA_W), .REG_W(REG_W), .NUM_CNT(NUM_CNT),
  .USER_BASE(USER_BASE), .PRIV_SHIFT(PRIV_SHIFT)
) i_chk (
  .clk(clk), .rst_n(rst_int_n), .req_valid(req_valid), .req_regnum(req_regnum),
  .req_write(req_write), .req_priv(req_priv), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault), .acc(ctl_acc)
);

// File: tb/test_pmu_access_gate.sv
module test_pmu_access_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [9:0]  req_regnum = '0;
  logic        req_write = 1'b0;
  logic        req_priv = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        rsp_grant;
  logic [1:0]  rsp_fault;

  always #2.5 clk = ~clk;

  pmu_access_gate i_pmu_access_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_regnum(req_regnum),
    .req_write(req_write), .req_priv(req_priv), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_grant(rsp_grant),
    .rsp_fault(rsp_fault)
  );

  typedef struct {
    logic        grant;
    logic [1:0]  fault;
    logic [63:0] rdata;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [63:0] mdl [8];
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  localparam logic [63:0] VIS0 = (64'd1 << 31) | (64'd1 << 26) | (64'd1 << 7);
  localparam logic [63:0] VIS2 = (64'd1 << 0) | (64'd1 << 9) | (64'd1 << 18) |
                                 (64'd1 << 27) | (64'd1 << 36) | (64'd1 << 45);

  task automatic issue(input logic wr, input logic pr, input logic [9:0] rn,
                       input logic [63:0] wd, input string tag);
    exp_t e;
    int   n = int'(rn);
    bit   ua = (n >= 'h40) && (n < 'h48);
    bit   pa = (n >= 'h50) && (n < 'h58);
    bit   mapped = ua || (pa && pr);
    int   k = ua ? n - 'h40 : n - 'h50;
    bit   um = ua && !pr;
    logic [63:0] m = '1;
    logic [1:0]  acc = mdl[6][19:18];
    @(negedge clk);
    if (um && k == 6) m = VIS0;
    if (um && k == 7) m = VIS2;
    e.fault = 2'b00;
    if (um) begin
      if (k >= 4 && k <= 5 && acc == 2'b11) e.fault = 2'b01;
      else if (wr) begin
        if (acc == 2'b00) e.fault = 2'b10;
        else if (acc == 2'b01) e.fault = 2'b01;
      end else if (acc == 2'b01) e.fault = 2'b01;
    end
    e.grant = mapped && (e.fault == 2'b00);
    e.rdata = (e.grant && !wr) ? (mdl[k] & m) : 64'd0;
    e.tag   = tag;
    if (e.grant && wr) mdl[k] = (mdl[k] & ~m) | (wd & m);
    sb_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_priv = pr; req_regnum = rn; req_wdata = wd;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_priv = 1'b0;
      req_regnum = '0; req_wdata = '0;
    end
  endtask

  always @(negedge clk) begin
    if (rsp_valid) begin
      exp_t e;
      n_vec++;
      if (sb_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1: unexpected response grant=%0b fault=%0b", rsp_grant, rsp_fault);
      end else begin
        e = sb_q.pop_front();
        if (rsp_grant !== e.grant || rsp_fault !== e.fault || rsp_rdata !== e.rdata) begin
          n_bad++;
          $display("FAIL %s: got grant=%0b fault=%0b data=%h, expected grant=%0b fault=%0b data=%h",
                   e.tag, rsp_grant, rsp_fault, rsp_rdata, e.grant, e.fault, e.rdata);
        end
      end
    end
  end

  task automatic check_quiet(input string tag);
    @(negedge clk);
    #0.5;
    n_vec++;
    if (rsp_valid !== 1'b0 || rsp_grant !== 1'b0 || rsp_fault !== 2'b00 || rsp_rdata !== 64'd0) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b grant=%0b fault=%0b data=%h, expected all zero",
               tag, rsp_valid, rsp_grant, rsp_fault, rsp_rdata);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    check_quiet("R12");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check_quiet("R1");

    // R12: everything reads zero
    for (int k = 0; k < 8; k++) issue(1'b0, 1'b1, 10'(16'h50 + k), '0, "R12");
    // R2: privileged fills, full width
    for (int k = 0; k < 6; k++)
      issue(1'b1, 1'b1, 10'(16'h50 + k), {32'hC0DE_0000 + 32'(k), 32'h1234_5678 ^ 32'(k)}, "R2");
    issue(1'b1, 1'b1, 10'h057, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    issue(1'b1, 1'b1, 10'h056, 64'hFFFF_FFFF_FFF3_FFFF, "R2");
    issue(1'b0, 1'b1, 10'h046, '0, "R2");
    issue(1'b0, 1'b1, 10'h055, '0, "R9");
    idle(1);
    check_quiet("R1");
    // field 00
    issue(1'b0, 1'b0, 10'h040, '0, "R3");
    issue(1'b0, 1'b0, 10'h044, '0, "R3");
    issue(1'b0, 1'b0, 10'h046, '0, "R6");
    issue(1'b0, 1'b0, 10'h047, '0, "R7");
    issue(1'b1, 1'b0, 10'h040, 64'hDEAD, "R4");
    issue(1'b0, 1'b1, 10'h050, '0, "R10");
    issue(1'b0, 1'b0, 10'h050, '0, "R11");
    issue(1'b1, 1'b0, 10'h056, 64'h0, "R11");
    issue(1'b0, 1'b1, 10'h056, '0, "R11");
    issue(1'b0, 1'b1, 10'h3FF, '0, "R11");
    issue(1'b1, 1'b1, 10'h048, 64'h55, "R11");
    issue(1'b0, 1'b1, 10'h058, '0, "R11");
    // field 01
    issue(1'b1, 1'b1, 10'h056, 64'h0000_0000_0004_0000, "R2");
    issue(1'b0, 1'b0, 10'h041, '0, "R3");
    issue(1'b0, 1'b0, 10'h045, '0, "R3");
    issue(1'b1, 1'b0, 10'h047, 64'h0, "R4");
    issue(1'b1, 1'b0, 10'h042, 64'h99, "R4");
    issue(1'b0, 1'b1, 10'h057, '0, "R10");
    issue(1'b0, 1'b1, 10'h052, '0, "R10");
    // field 10
    issue(1'b1, 1'b1, 10'h056, 64'h0000_0000_0008_0000, "R2");
    issue(1'b1, 1'b0, 10'h046, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    issue(1'b0, 1'b0, 10'h046, '0, "R6");
    issue(1'b0, 1'b1, 10'h056, '0, "R8");
    issue(1'b1, 1'b0, 10'h047, 64'h0, "R8");
    issue(1'b0, 1'b1, 10'h057, '0, "R8");
    issue(1'b0, 1'b0, 10'h047, '0, "R7");
    issue(1'b1, 1'b0, 10'h044, 64'hFEED_FACE_0BAD_CAFE, "R8");
    issue(1'b0, 1'b1, 10'h054, '0, "R8");
    idle(2);
    // field 11
    issue(1'b1, 1'b1, 10'h046, 64'h0000_0000_000C_0000, "R2");
    issue(1'b0, 1'b0, 10'h044, '0, "R5");
    issue(1'b1, 1'b0, 10'h045, 64'h1, "R5");
    issue(1'b0, 1'b1, 10'h055, '0, "R10");
    issue(1'b0, 1'b0, 10'h040, '0, "R3");
    issue(1'b1, 1'b0, 10'h043, 64'h7777, "R4");
    issue(1'b0, 1'b0, 10'h043, '0, "R4");
    issue(1'b1, 1'b0, 10'h046, 64'h0, "R8");
    issue(1'b0, 1'b1, 10'h056, '0, "R8");
    issue(1'b0, 1'b0, 10'h047, '0, "R7");
    idle(3);
    check_quiet("R1");
    if (sb_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d responses missing, expected 0", sb_q.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule